// File: doc/BRIEF.md
# Two-Level 32-bit Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by walking a two-level page table held in memory. A requester hands over a virtual address together with an access kind on a valid/ready pair. The walker reads the translation mode and the root table page number from a translation control register input. It then fetches page table entries through a read port whose data returns a fixed number of cycles after each read strobe. The walker answers with the physical address and the leaf entry, or with a not-found flag. A separate permission checker consumes that answer.

When the mode bit is clear, the walker is a pass-through. When the mode bit is set, it walks at most two levels. It detects leaves at either level and rejects a level-1 leaf whose physical page number is not aligned. It also rejects any table page that lies beyond the installed physical memory. Only one walk is in flight at a time.

Top module: `sv32_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_req` is 0.
- R2: When `satp_i[31]` is 0 at acceptance, the response has `resp_ok`=1 and `resp_paddr` equal to the zero-extended virtual address. It arrives one cycle after acceptance and no memory read is issued.
- R3: When `satp_i[31]` is 1, the root table page is `satp_i[21:0]` and bits 30:22 have no effect. The first read goes to root*4096 + VA[31:22]*4 in the cycle after acceptance. A second-level read goes to ppn*4096 + VA[21:12]*4.
- R4: Read data is taken exactly MEM_LAT cycles after the cycle in which `mem_req` is high. The next read, or the response, follows in the next cycle.
- R5: A PTE has V at bit 0, R at bit 1, W at bit 2 and X at bit 3, and its page number in bits 31:10. A valid entry with R or X set is a leaf. A valid entry with R, W and X all clear points to the next table.
- R6: A leaf found at level 0 gives `resp_ok`=1, `resp_paddr` = {PTE[31:10], VA[11:0]}, and `resp_pte` equal to the entry.
- R7: A leaf found at level 1 with PTE[19:10]=0 gives `resp_paddr` = {PTE[31:20], VA[21:0]} and `resp_ok`=1. If PTE[19:10] is nonzero, the result is not-found.
- R8: A walk ends as not-found (`resp_ok`=0) on an entry with V=0, on an entry with W set and R clear, or on a pointer entry at level 0.
- R9: A root or next-level table page number at or above MEM_PAGES ends the walk as not-found without reading that table. For the root, the answer comes one cycle after acceptance.
- R10: `req_ready` stays 0 from acceptance until the response handshake completes. While `resp_ready` is 0, the response holds steady. `resp_kind` returns the kind given with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| satp_i | input | 32 | Translation control: bit 31 mode, bits 21:0 root page |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | KIND_W | Access kind, passed through |
| mem_req | output | 1 | Word read strobe |
| mem_addr | output | 34 | Byte address of the PTE read |
| mem_rdata | input | 32 | Read data, valid MEM_LAT cycles after the strobe |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response accepted |
| resp_ok | output | 1 | 1 = translation found, 0 = not-found |
| resp_paddr | output | 34 | Physical address |
| resp_pte | output | 32 | Leaf entry (0 in bare mode) |
| resp_kind | output | KIND_W | Echo of the request kind |

## Verification
A bare or root-rejected request is answered one cycle after acceptance. Each table read adds MEM_LAT+1 cycles, so a walk with n reads answers n*(MEM_LAT+1)+1 cycles after acceptance. The reference model counts the reads its own walk performs and derives the response cycle from that count. On every clock it compares `resp_valid`, `req_ready` and each `mem_addr` against the expectation. Read data is driven only in the due cycle and holds a misleading leaf value otherwise, so a walker that samples early or late produces a wrong answer.

// File: rtl/sv32_walker.sv
module sv32_walker #(
  parameter int MEM_LAT   = 2,
  parameter int MEM_PAGES = 1024,
  parameter int KIND_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       satp_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic [KIND_W-1:0] req_kind,
  output logic              mem_req,
  output logic [33:0]       mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_ok,
  output logic [33:0]       resp_paddr,
  output logic [31:0]       resp_pte,
  output logic [KIND_W-1:0] resp_kind
);
  localparam int          CNT_W    = (MEM_LAT < 2) ? 1 : $clog2(MEM_LAT + 1);
  localparam logic [32:0] PG_LIMIT = 33'(MEM_PAGES);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_t;

  state_t             st;
  logic [31:0]        va_q;
  logic [KIND_W-1:0]  kind_q;
  logic [21:0]        tbl_q;
  logic               lvl_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               ok_q;
  logic [33:0]        pa_q;
  logic [31:0]        pte_q;

  function automatic logic page_ok(input logic [21:0] p);
    return {11'd0, p} < PG_LIMIT;
  endfunction

  wire [9:0] vpn     = lvl_q ? va_q[31:22] : va_q[21:12];
  wire       pte_v   = mem_rdata[0];
  wire       pte_r   = mem_rdata[1];
  wire       pte_w   = mem_rdata[2];
  wire       pte_x   = mem_rdata[3];

  assign req_ready  = (st == S_IDLE);
  assign mem_req    = (st == S_ISSUE);
  assign mem_addr   = {tbl_q, 12'd0} + {22'd0, vpn, 2'b00};
  assign resp_valid = (st == S_RESP);
  assign resp_ok    = ok_q;
  assign resp_paddr = pa_q;
  assign resp_pte   = pte_q;
  assign resp_kind  = kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      kind_q <= '0;
      tbl_q  <= '0;
      lvl_q  <= 1'b1;
      cnt_q  <= '0;
      ok_q   <= 1'b0;
      pa_q   <= '0;
      pte_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          kind_q <= req_kind;
          lvl_q  <= 1'b1;
          tbl_q  <= satp_i[21:0];
          pte_q  <= '0;
          ok_q   <= 1'b0;
          pa_q   <= '0;
          if (!satp_i[31]) begin
            ok_q <= 1'b1;
            pa_q <= {2'b00, req_vaddr};
            st   <= S_RESP;
          end else if (!page_ok(satp_i[21:0])) begin
            st <= S_RESP;
          end else begin
            st <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          cnt_q <= CNT_W'(MEM_LAT - 1);
          st    <= S_WAIT;
        end
        S_WAIT: if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          st <= S_RESP;
          if (!pte_v || (pte_w && !pte_r)) begin
            ok_q <= 1'b0;
          end else if (pte_r || pte_x) begin
            if (!lvl_q) begin
              ok_q  <= 1'b1;
              pte_q <= mem_rdata;
              pa_q  <= {mem_rdata[31:10], va_q[11:0]};
            end else if (mem_rdata[19:10] == 10'd0) begin
              ok_q  <= 1'b1;
              pte_q <= mem_rdata;
              pa_q  <= {mem_rdata[31:20], va_q[21:0]};
            end
          end else if (lvl_q && page_ok(mem_rdata[31:10])) begin
            tbl_q <= mem_rdata[31:10];
            lvl_q <= 1'b0;
            st    <= S_ISSUE;
          end
        end
        S_RESP: if (resp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_BUSY_WHILE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready); // R10
  AST_ANSWER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_ok) && $stable(resp_paddr) && $stable(resp_kind)); // R10
  AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R10
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R4
  AST_BARE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !satp_i[31] |=> resp_valid && resp_ok && resp_paddr == {2'b00, $past(req_vaddr)}); // R2
  AST_ROOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && satp_i[31] && ({11'd0, satp_i[21:0]} >= PG_LIMIT) |=> resp_valid && !resp_ok); // R9
  AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && satp_i[31] && ({11'd0, satp_i[21:0]} < PG_LIMIT) |=> mem_req); // R3
endmodule

// File: tb/sv32_walker_tb.sv
module sv32_walker_tb;
  localparam int LAT   = 2;
  localparam int PAGES = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] satp_r = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        mem_req;
  logic [33:0] mem_addr;
  logic [31:0] mem_rdata = 32'hFFFF_FC0F;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic        resp_ok;
  logic [33:0] resp_paddr;
  logic [31:0] resp_pte;
  logic [1:0]  resp_kind;

  sv32_walker #(.MEM_LAT(LAT), .MEM_PAGES(PAGES), .KIND_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .satp_i(satp_r),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_ok(resp_ok),
    .resp_paddr(resp_paddr), .resp_pte(resp_pte), .resp_kind(resp_kind));

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [31:0] pmem [logic [31:0]];
  longint      exp_addr_q [$];
  int          due_q [$];
  longint      rd_addr_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit good, input string tag, input longint act, input longint exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] rd_word(input longint a);
    logic [31:0] w;
    w = 32'(a >> 2);
    return pmem.exists(w) ? pmem[w] : 32'h0;
  endfunction

  // memory responder with fixed latency; garbage outside the due cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        mem_rdata <= rd_word(rd_addr_q[0]);
        void'(due_q.pop_front());
        void'(rd_addr_q.pop_front());
      end else begin
        mem_rdata <= 32'hFFFF_FC0F;
      end
      if (mem_req) begin
        due_q.push_back(cyc + LAT);
        rd_addr_q.push_back(longint'(mem_addr));
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, "R3 unexpected read", longint'(mem_addr), 0);
        end else begin
          chk(longint'(mem_addr) == exp_addr_q[0], "R3 read address", longint'(mem_addr), exp_addr_q[0]);
          void'(exp_addr_q.pop_front());
        end
      end
    end
  end

  // behavioural reference walk
  task automatic model(input logic [31:0] satp, input logic [31:0] va,
                       output bit ok, output longint pa, output longint pte, output int nrd);
    longint tbl, a;
    logic [31:0] e;
    ok = 0; pa = 0; pte = 0; nrd = 0;
    if (!satp[31]) begin ok = 1; pa = longint'(va); return; end
    tbl = longint'(satp & 32'h003F_FFFF);
    if (tbl >= PAGES) return;
    for (int lvl = 1; lvl >= 0; lvl--) begin
      a = tbl * 4096 + ((lvl == 1) ? longint'(va >> 22) : longint'((va >> 12) & 32'h3FF)) * 4;
      exp_addr_q.push_back(a);
      nrd++;
      e = rd_word(a);
      if (!e[0]) return;
      if (e[2] && !e[1]) return;
      if (e[1] || e[3]) begin
        if (lvl == 1) begin
          if (((e >> 10) & 32'h3FF) != 0) return;
          pa = longint'(e >> 20) * 64'h40_0000 + longint'(va & 32'h003F_FFFF);
        end else begin
          pa = longint'(e >> 10) * 4096 + longint'(va & 32'hFFF);
        end
        ok = 1; pte = longint'(e);
        return;
      end
      if (lvl == 0) return;
      tbl = longint'(e >> 10);
      if (tbl >= PAGES) return;
    end
  endtask

  task automatic run(input logic [31:0] satp, input logic [31:0] va, input logic [1:0] kind,
                     input int hold, input string tag);
    bit ok; longint pa, pte; int nrd, expc;
    @(negedge clk);
    satp_r = satp; req_vaddr = va; req_kind = kind; req_valid = 1'b1;
    chk(req_ready == 1'b1, {tag, " R10 ready before"}, req_ready, 1);
    model(satp, va, ok, pa, pte, nrd);
    expc = cyc + ((nrd == 0) ? 1 : nrd * (LAT + 1) + 1);
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = 32'h5A5A_5A5A;
    while (cyc < expc) begin
      chk(resp_valid == 1'b0, {tag, " R4 early answer"}, resp_valid, 0);
      chk(req_ready == 1'b0, {tag, " R10 ready during walk"}, req_ready, 0);
      @(negedge clk);
    end
    chk(resp_valid == 1'b1, {tag, " R4 answer due"}, resp_valid, 1);
    chk(resp_ok == ok, {tag, " R8 ok flag"}, resp_ok, ok);
    if (ok) begin
      chk(longint'(resp_paddr) == pa, {tag, " R6 R7 paddr"}, longint'(resp_paddr), pa);
      chk(longint'(resp_pte) == pte, {tag, " R6 pte"}, longint'(resp_pte), pte);
    end
    chk(resp_kind == kind, {tag, " R10 kind"}, resp_kind, kind);
    if (hold > 0) begin
      resp_ready = 1'b0;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(resp_valid == 1'b1 && resp_ok == ok, {tag, " R10 held"}, resp_valid, 1);
        chk(req_ready == 1'b0, {tag, " R10 busy while held"}, req_ready, 0);
        if (ok) chk(longint'(resp_paddr) == pa, {tag, " R10 paddr held"}, longint'(resp_paddr), pa);
      end
      resp_ready = 1'b1;
    end
    @(negedge clk);
    chk(resp_valid == 1'b0, {tag, " R10 answer retired"}, resp_valid, 0);
    chk(req_ready == 1'b1, {tag, " R10 ready after"}, req_ready, 1);
    chk(exp_addr_q.size() == 0, {tag, " R3 reads missing"}, exp_addr_q.size(), 0);
    exp_addr_q.delete();
  endtask

  initial begin
    pmem[32'h10004 >> 2]  = 32'h0000_8001;
    pmem[32'h20014 >> 2]  = (32'h30055 << 10) | 32'h7;
    pmem[32'h100C0 >> 2]  = (32'h2C00 << 10) | 32'hB;
    pmem[32'h100C4 >> 2]  = (32'h2C01 << 10) | 32'hB;
    pmem[32'h100CC >> 2]  = 32'h5;
    pmem[32'h100D0 >> 2]  = (32'h21 << 10) | 32'h1;
    pmem[32'h21000 >> 2]  = (32'h22 << 10) | 32'h1;
    pmem[32'h100D4 >> 2]  = (32'h400 << 10) | 32'h1;
    pmem[32'h100D8 >> 2]  = (32'h3FF << 10) | 32'h1;
    pmem[32'h3FF01C >> 2] = (32'h12345 << 10) | 32'h9;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(resp_valid == 1'b0, "R1 resp_valid", resp_valid, 0);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);

    run(32'h7FC0_0123, 32'hDEAD_BEEF, 2'd1, 0, "R2 bare");
    run(32'hFFC0_0010, 32'h0040_5ABC, 2'd2, 3, "R3 R6 4k leaf");
    run(32'h8000_0010, 32'h0C12_3456, 2'd0, 0, "R7 superpage");
    run(32'h8000_0010, 32'h0C40_0ABC, 2'd1, 0, "R7 misaligned");
    run(32'h8000_0010, 32'h0C80_0000, 2'd2, 0, "R8 invalid l1");
    run(32'h8000_0010, 32'h0CC0_0000, 2'd3, 0, "R8 write only");
    run(32'h8000_0010, 32'h0D00_0000, 2'd0, 2, "R8 pointer at l0");
    run(32'h8000_0010, 32'h0040_6000, 2'd1, 0, "R8 invalid l0");
    run(32'h8000_0400, 32'h0040_5ABC, 2'd2, 0, "R9 root range");
    run(32'h8000_0010, 32'h0D40_0000, 2'd3, 0, "R9 next range");
    run(32'h8000_0010, 32'h0D80_7123, 2'd1, 0, "R5 R9 last page exec leaf");
    run(32'h0000_0010, 32'h0040_5ABC, 2'd0, 1, "R2 bare held");

    chk(resp_paddr == 34'h0_0040_5ABC, "R2 bare paddr literal", longint'(resp_paddr), 64'h405ABC);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule